// File: doc/BRIEF.md
# Overlapping Push-Pull Drive Sequencer

This block produces the gate commands for a current-fed push-pull power stage: two main switches and one auxiliary switch that lets the main switches turn off at zero current. One fixed-frequency clock pulse marks every switching period. The pulse width is the dead time, because all three drives are off for as long as the pulse is high. The main switches take turns being the primary switch, one per period, so each switches at half the pulse rate. During the first part of each period, while the current loop's PWM request is high, the non-primary switch is also on. This overlap is the boost charge interval.

The auxiliary drive turns on at the end of each clock pulse. It stays on past the end of the overlap for an adaptive delay. A counter models the delay ramp. The counter is held at zero while the overlap lasts and counts up after it ends. The auxiliary drive ends when the count passes a limit taken from the load-demand code, so a larger load gives a longer hold-on. Three conditions remove both the overlap and the auxiliary drive: a peak-current fault, a load-demand code below the zero-power level, or a disabled delay function (which removes only the added delay).

Top module: `pp_overlap_seq`

## Requirements
- R1: While reset is active, or in the cycle after `enable` is sampled low, all three drives are low. Disabling returns the primary-phase selection to its first phase (A).
- R2: In the cycle after any edge where `clkPulse` is sampled high, all three drives are low.
- R3: In each cycle of a period after its pulse, the primary main drive is high. The primary is A and B in turn, and it changes at every rising pulse edge after the first one.
- R4: The non-primary main drive is also high in low-pulse cycle j (j counted from 0 after the pulse) exactly when `pwmReq` was high in cycles 0..j. Once `pwmReq` is seen low in a period, the overlap stays off until the next pulse.
- R5: With `delayOn` high, the auxiliary drive is high in low-pulse cycles j < H + L. H is the number of overlap cycles and L = `demand` >> 2 (top four bits of the 6-bit code), so a larger code gives a longer hold-on.
- R6: Every output is registered and reflects the inputs sampled at the preceding clock edge.
- R7: With `delayOn` low, L = 0 and the auxiliary drive ends in the same cycle as the overlap.
- R8: A `demand` code below 8 (the zero-power level) gives no overlap and no auxiliary drive for the whole period.
- R9: `peakFault` sampled high at low-pulse cycle F drives the auxiliary drive low and ends the overlap from that cycle on. Both stay off until the next pulse, even after the fault clears.
- R10: After enable, all drives stay low until the first pulse. The period after that first pulse uses A as primary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low forces all drives off |
| clkPulse | input | 1 | Oscillator pulse marking each period; its width is the dead time |
| pwmReq | input | 1 | PWM on request from the current loop |
| demand | input | DEMAND_W (6) | Load-demand code from the voltage loop |
| peakFault | input | 1 | Peak-current fault flag |
| delayOn | input | 1 | Enables the adaptive auxiliary hold-on delay |
| driveA | output | 1 | Main switch A gate command |
| driveB | output | 1 | Main switch B gate command |
| driveAux | output | 1 | Auxiliary switch gate command |

## Verification
The bench runs a continuous stream of periods. It sweeps every overlap length from zero to the full low time, for pulse widths of one and two cycles, over demand codes below, at and above the zero-power level, with the delay enabled and disabled. These patterns separate the hold-on formula from the overlap length, and they separate the zero-power suppression from a short delay. A subset repeats with a one-cycle fault in mid-period, before and after the overlap would end, to show that both the overlap and the auxiliary drive stay latched off. Disable and re-enable, plus idle cycles before the first pulse, confirm that the alternation restarts on switch A.

// File: rtl/pp_seq_pkg.sv
package pp_seq_pkg;
  // Strobes passed from the sequencing control to the delay datapath
  typedef struct packed {
    logic clearCnt;  // hold the delay ramp at zero (pulse or overlap active)
    logic flush;     // synchronous clear while disabled
  } seqStrobe_t;
endpackage

// File: rtl/pp_seq_delay.sv
module pp_seq_delay
  import pp_seq_pkg::*;
#(
  parameter int DEMAND_W    = 6,
  parameter int DELAY_SHIFT = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DEMAND_W-1:0] demand,
  input  logic                delayOn,
  input  seqStrobe_t          strobe,
  output logic                expired
);
  localparam int LIMIT_W = DEMAND_W - DELAY_SHIFT;
  localparam int CNT_W   = LIMIT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [LIMIT_W-1:0] limit;
  logic [CNT_W-1:0]   rampCnt, rampNext;

  // Delay limit derived from the load-demand code; zero when delay disabled
  assign limit = delayOn ? demand[DEMAND_W-1:DELAY_SHIFT] : '0;

  always_comb begin
    if (strobe.flush || strobe.clearCnt)
      rampNext = '0;
    else if (rampCnt == CNT_MAX)
      rampNext = rampCnt;
    else
      rampNext = rampCnt + 1'b1;
  end

  // Ramp has crossed the demand level once the count passes the limit
  assign expired = rampNext > {1'b0, limit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rampCnt <= '0;
    else        rampCnt <= rampNext;
  end
endmodule

// File: rtl/pp_seq_control.sv
module pp_seq_control
  import pp_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       clkPulse,
  input  logic       pwmReq,
  input  logic       blockOverlap,
  input  logic       expired,
  output seqStrobe_t strobe,
  output logic       driveA,
  output logic       driveB,
  output logic       driveAux
);
  logic pulsePrev, running, phaseSel, pwmArm, delayHi;
  logic runNext, phaseNext, armNext, delayNext, pwmNow, pulseRise;
  logic aNext, bNext, auxNext;

  assign pulseRise = clkPulse && !pulsePrev;
  assign runNext   = enable && (running || clkPulse);

  always_comb begin
    if (!enable) begin
      phaseNext = 1'b0;
      armNext   = 1'b0;
      delayNext = 1'b0;
    end else begin
      phaseNext = (pulseRise && running) ? !phaseSel : phaseSel;
      armNext   = clkPulse ? 1'b1 : (pwmArm && pwmReq && !blockOverlap);
      delayNext = clkPulse ? 1'b1 : (delayHi && !blockOverlap && !expired);
    end
  end

  assign pwmNow = armNext && !clkPulse;

  assign strobe.clearCnt = clkPulse || pwmNow;
  assign strobe.flush    = !enable;

  assign aNext   = runNext && !clkPulse && (!phaseNext || pwmNow);
  assign bNext   = runNext && !clkPulse && ( phaseNext || pwmNow);
  assign auxNext = runNext && !clkPulse && delayNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulsePrev <= 1'b0;
      running   <= 1'b0;
      phaseSel  <= 1'b0;
      pwmArm    <= 1'b0;
      delayHi   <= 1'b0;
      driveA    <= 1'b0;
      driveB    <= 1'b0;
      driveAux  <= 1'b0;
    end else begin
      pulsePrev <= clkPulse;
      running   <= runNext;
      phaseSel  <= phaseNext;
      pwmArm    <= armNext;
      delayHi   <= delayNext;
      driveA    <= aNext;
      driveB    <= bNext;
      driveAux  <= auxNext;
    end
  end
endmodule

// File: rtl/pp_overlap_seq.sv
module pp_overlap_seq
  import pp_seq_pkg::*;
#(
  parameter int DEMAND_W    = 6,
  parameter int DELAY_SHIFT = 2,
  parameter int ZERO_LEVEL  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                clkPulse,
  input  logic                pwmReq,
  input  logic [DEMAND_W-1:0] demand,
  input  logic                peakFault,
  input  logic                delayOn,
  output logic                driveA,
  output logic                driveB,
  output logic                driveAux
);
  localparam logic [DEMAND_W-1:0] ZERO_CODE = DEMAND_W'(ZERO_LEVEL);

  seqStrobe_t strobe;
  logic       expired;
  logic       blockOverlap;

  assign blockOverlap = peakFault || (demand < ZERO_CODE);

  pp_seq_control ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clkPulse(clkPulse),
    .pwmReq(pwmReq), .blockOverlap(blockOverlap), .expired(expired),
    .strobe(strobe), .driveA(driveA), .driveB(driveB), .driveAux(driveAux)
  );

  pp_seq_delay #(.DEMAND_W(DEMAND_W), .DELAY_SHIFT(DELAY_SHIFT)) dpath (
    .clk(clk), .rst_n(rst_n), .demand(demand), .delayOn(delayOn),
    .strobe(strobe), .expired(expired)
  );
endmodule

// File: rtl/pp_overlap_seq_checker.sv
module pp_overlap_seq_checker #(
  parameter int DEMAND_W   = 6,
  parameter int ZERO_LEVEL = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enable,
  input logic                clkPulse,
  input logic [DEMAND_W-1:0] demand,
  input logic                peakFault,
  input logic                driveA,
  input logic                driveB,
  input logic                driveAux
);
  localparam logic [DEMAND_W-1:0] ZERO_CODE = DEMAND_W'(ZERO_LEVEL);

  assert_disable_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!enable) |-> (!driveA && !driveB && !driveAux));

  assert_pulse_dead_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clkPulse) |-> (!driveA && !driveB && !driveAux));

  assert_overlap_in_aux_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (driveA && driveB) |-> driveAux);

  assert_zero_power_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(demand < ZERO_CODE) |-> (!driveAux && !(driveA && driveB)));

  assert_fault_cut_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(peakFault) |-> (!driveAux && !(driveA && driveB)));
endmodule

bind pp_overlap_seq pp_overlap_seq_checker #(.DEMAND_W(DEMAND_W), .ZERO_LEVEL(ZERO_LEVEL)) chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .clkPulse(clkPulse), .demand(demand),
  .peakFault(peakFault), .driveA(driveA), .driveB(driveB), .driveAux(driveAux)
);

// File: tb/pp_overlap_seq_test.sv
`timescale 1ns/1ps
module pp_overlap_seq_test;
  localparam int LOW_N = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       clkPulse = 1'b0;
  logic       pwmReq = 1'b0;
  logic [5:0] demand = 6'd0;
  logic       peakFault = 1'b0;
  logic       delayOn = 1'b0;
  logic       driveA, driveB, driveAux;

  int checks = 0;
  int failures = 0;
  int periodIdx = 0;
  bit finished = 1'b0;

  pp_overlap_seq uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clkPulse(clkPulse),
    .pwmReq(pwmReq), .demand(demand), .peakFault(peakFault), .delayOn(delayOn),
    .driveA(driveA), .driveB(driveB), .driveAux(driveAux)
  );

  always #10 clk = ~clk;

  task automatic checkBit(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b (period %0d)", req, what, act, exp, periodIdx);
    end
  endtask

  task automatic stepCycle();
    @(posedge clk);
    #1;
  endtask

  task automatic checkAllLow(input string req);
    checkBit(req, "driveA", driveA, 1'b0);
    checkBit(req, "driveB", driveB, 1'b0);
    checkBit(req, "driveAux", driveAux, 1'b0);
  endtask

  // One switching period: w pulse cycles then LOW_N low cycles.
  task automatic runPeriod(input int w, input int h, input int d, input bit dOn, input int f);
    int lim, ovEnd, auxEnd;
    bit blocked, primA;
    string auxTag, mainTag;
    demand  = 6'(d);
    delayOn = dOn;
    for (int c = 0; c < w; c++) begin
      clkPulse = 1'b1; pwmReq = 1'b1; peakFault = 1'b0;
      stepCycle();
      checkAllLow("R2");
    end
    lim     = dOn ? (d >> 2) : 0;
    blocked = (d < 8);
    ovEnd   = blocked ? 0 : ((f >= 0 && f < h) ? f : h);
    auxEnd  = blocked ? 0 : ((f >= 0 && f < h + lim) ? f : h + lim);
    primA   = (periodIdx % 2 == 0);
    mainTag = (periodIdx == 0) ? "R10" : "R3";
    if (blocked) auxTag = "R8";
    else if (f >= 0 && f < h + lim) auxTag = "R9";
    else if (dOn) auxTag = "R5";
    else auxTag = "R7";
    for (int j = 0; j < LOW_N; j++) begin
      clkPulse  = 1'b0;
      pwmReq    = (j < h);
      peakFault = (j == f);
      stepCycle();
      // R6: outputs reflect this cycle's inputs one edge later, sampled here
      checkBit(primA ? mainTag : "R4", "driveA", driveA, primA || (j < ovEnd));
      checkBit(primA ? "R4" : mainTag, "driveB", driveB, !primA || (j < ovEnd));
      checkBit(auxTag, "driveAux", driveAux, j < auxEnd);
    end
    peakFault = 1'b0;
    periodIdx++;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stimulus
    int dList[6];
    dList = '{0, 5, 8, 13, 31, 63};
    // R1: reset state
    repeat (3) stepCycle();
    checkAllLow("R1");
    rst_n = 1'b1;
    stepCycle();
    checkAllLow("R1");
    // R10: enabled but no pulse yet
    enable = 1'b1; pwmReq = 1'b1; demand = 6'd40; delayOn = 1'b1;
    for (int i = 0; i < 4; i++) begin
      stepCycle();
      checkAllLow("R10");
    end
    periodIdx = 0;
    // Main sweep
    for (int w = 1; w <= 2; w++)
      for (int di = 0; di < 6; di++)
        for (int dOn = 0; dOn < 2; dOn++)
          for (int fi = 0; fi < 2; fi++)
            for (int h = 0; h <= LOW_N; h++)
              runPeriod(w, h, dList[di], dOn[0], fi ? 3 + (h % 7) : -1);
    // R1: disable in mid-stream, then restart on phase A
    runPeriod(1, 5, 40, 1'b1, -1);
    enable = 1'b0; clkPulse = 1'b1; pwmReq = 1'b1;
    stepCycle();
    checkAllLow("R1");
    clkPulse = 1'b0;
    for (int i = 0; i < 3; i++) begin
      stepCycle();
      checkAllLow("R1");
    end
    enable = 1'b1;
    stepCycle();
    checkAllLow("R10");
    periodIdx = 0;
    for (int p = 0; p < 4; p++) runPeriod(1, 4 + p, 48, 1'b1, -1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule